// File: doc/BRIEF.md
# Fan Speed Controller with Start-Up Boost

This block holds a 3-bit fan speed setting and drives four active-low control lines: one shutdown line and three speed-select lines. A setting of zero stops the fan. Codes 1 through 7 run from the slowest speed to the fastest.

A stalled fan may not spin up reliably at a low speed. For that reason, any write that moves the setting from zero to a non-zero code first applies the fastest code for a start-up interval. After the interval the stored code takes effect. The interval is counted by a prescaler and a tick counter, so its length is `PRESCALE_DIV * KICK_TICKS` clock cycles.

The four lines are also presented as open-drain pull-down enables for port bits 7 to 4. These enables are active only while fan mode is selected.

Top module: `fan_kick_ctrl`

## Requirements
- R1: After reset, `rd_data` is 0x00, `shdn_n` is 0, `fs_n` is 3'b111, and `od_pull` is 4'b0000 while `fan_mode` is 0.
- R2: A cycle with `wr_en` high stores `wr_speed` into the setting. The value appears on `rd_data[2:0]` after that clock edge, and `rd_data[7:3]` always reads zero.
- R3: Outside a start-up interval the effective code equals the stored setting. `shdn_n` is 1 exactly when the effective code is non-zero, and `fs_n` equals the bitwise inverse of the effective code.
- R4: A write of a non-zero code while the setting is zero starts a start-up interval. The effective code is then 7 (`fs_n` = 3'b000, `shdn_n` = 1) for exactly `PRESCALE_DIV*KICK_TICKS` cycles, starting with the cycle after the write edge. After that the stored code applies.
- R5: A non-zero write while the setting is already non-zero and no interval is running changes the outputs on the next cycle, with no start-up interval.
- R6: A non-zero write during a start-up interval updates the stored setting but does not restart or extend the interval. The new code applies when the original interval ends.
- R7: A write of zero during a start-up interval ends the interval at once, so the next cycle shows `shdn_n` = 0 and `fs_n` = 3'b111. A later non-zero write starts a full new interval.
- R8: With `fan_mode` = 1, `od_pull[0]` = ~`shdn_n` and `od_pull[3:1]` = ~`fs_n[2:0]` (bit 0 maps to port bit 4, bits 1 to 3 map to port bits 5 to 7). With `fan_mode` = 0, `od_pull` is 4'b0000.
- R9: A write of zero while the setting is already zero leaves the fan off and starts no interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fan_mode | input | 1 | Hands port bits 7..4 to the fan outputs |
| wr_en | input | 1 | Write strobe for the speed setting |
| wr_speed | input | 3 | Speed code to store |
| rd_data | output | 8 | Setting readback, bits 7..3 zero |
| shdn_n | output | 1 | Active-low fan shutdown |
| fs_n | output | 3 | Active-low speed-select lines |
| od_pull | output | 4 | Open-drain pull-low enables for port bits 7..4 |

## Verification
The bench measures the boost length at its last boosted cycle and at the first cycle after it. An off-by-one prescaler or tick counter would therefore show up as one cycle too many or too few.

It rewrites the speed in the middle of a boost. A design that restarts the timer would hold the fastest code past the original end.

It also writes zero in the middle of a boost. A design that lets the timer run out would keep driving the fan at full speed after the stop command.

Finally, it writes zero while the fan is already off, which catches a start test that fires on any write. It toggles fan mode to catch pull enables that leak onto the port while the port is in normal I/O use.

// File: rtl/fan_kick_ctrl.sv
module fan_kick_ctrl #(
  parameter int PRESCALE_DIV = 1000,
  parameter int KICK_TICKS   = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fan_mode,
  input  logic       wr_en,
  input  logic [2:0] wr_speed,
  output logic [7:0] rd_data,
  output logic       shdn_n,
  output logic [2:0] fs_n,
  output logic [3:0] od_pull
);
  localparam int PW = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
  localparam int TW = $clog2(KICK_TICKS + 1);

  logic [2:0]    speed_q;
  logic [PW-1:0] pre_q;
  logic [TW-1:0] tick_q;
  logic          boosting;
  logic          start_boost;
  logic          stop_fan;
  logic [2:0]    eff_code;

  assign boosting    = (tick_q != '0);
  assign start_boost = wr_en && (speed_q == 3'd0) && (wr_speed != 3'd0);
  assign stop_fan    = wr_en && (wr_speed == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed_q <= 3'd0;
      pre_q   <= '0;
      tick_q  <= '0;
    end else begin
      if (wr_en) speed_q <= wr_speed;
      if (stop_fan) begin
        tick_q <= '0;
        pre_q  <= '0;
      end else if (start_boost) begin
        tick_q <= TW'(KICK_TICKS);
        pre_q  <= '0;
      end else if (boosting) begin
        if (pre_q == PW'(PRESCALE_DIV - 1)) begin
          pre_q  <= '0;
          tick_q <= tick_q - TW'(1);
        end else begin
          pre_q <= pre_q + PW'(1);
        end
      end
    end
  end

  assign eff_code = boosting ? 3'b111 : speed_q;
  assign shdn_n   = (eff_code != 3'd0);
  assign fs_n     = ~eff_code;
  assign od_pull  = fan_mode ? {~fs_n, ~shdn_n} : 4'b0000;
  assign rd_data  = {5'b00000, speed_q};
endmodule

// File: rtl/fan_kick_ctrl_chk.sv
module fan_kick_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fan_mode,
  input logic       wr_en,
  input logic [2:0] wr_speed,
  input logic [7:0] rd_data,
  input logic       shdn_n,
  input logic [2:0] fs_n,
  input logic [3:0] od_pull
);
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:3] == 5'b00000); // R2
  AST_SHDN_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_n == (fs_n != 3'b111)); // R3
  AST_BOOST_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_data == 8'h00 && wr_speed != 3'd0) |=> (fs_n == 3'b000 && shdn_n)); // R4
  AST_STEADY_REWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_data != 8'h00 && rd_data != 8'h07 && wr_speed != 3'd0 && fs_n == ~rd_data[2:0])
    |=> fs_n == ~$past(wr_speed)); // R5
  AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_speed == 3'd0) |=> (!shdn_n && fs_n == 3'b111)); // R7
  AST_NO_PULL_OUTSIDE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !fan_mode |-> od_pull == 4'b0000); // R8
  AST_PULL_FOLLOWS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    fan_mode |-> od_pull == {~fs_n, ~shdn_n}); // R8
endmodule

bind fan_kick_ctrl fan_kick_ctrl_chk i_chk (.*);

// File: tb/test_fan_kick_ctrl.sv
module test_fan_kick_ctrl;
  localparam int PD = 3;
  localparam int KT = 5;
  localparam int K  = PD * KT;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fan_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_speed = 3'd0;
  logic [7:0] rd_data;
  logic       shdn_n;
  logic [2:0] fs_n;
  logic [3:0] od_pull;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fan_kick_ctrl #(.PRESCALE_DIV(PD), .KICK_TICKS(KT)) i_fan_kick_ctrl (
    .clk(clk), .rst_n(rst_n), .fan_mode(fan_mode), .wr_en(wr_en),
    .wr_speed(wr_speed), .rd_data(rd_data), .shdn_n(shdn_n),
    .fs_n(fs_n), .od_pull(od_pull)
  );

  // {fan_mode, wr_speed, exp_rd[2:0], exp_shdn_n, exp_fs_n, exp_pull}
  localparam logic [14:0] VEC [8] = '{
    {1'b1, 3'd3, 3'd3, 1'b1, 3'b100, 4'b0110},
    {1'b1, 3'd7, 3'd7, 1'b1, 3'b000, 4'b1110},
    {1'b0, 3'd1, 3'd1, 1'b1, 3'b110, 4'b0000},
    {1'b1, 3'd5, 3'd5, 1'b1, 3'b010, 4'b1010},
    {1'b1, 3'd0, 3'd0, 1'b0, 3'b111, 4'b0001},
    {1'b0, 3'd0, 3'd0, 1'b0, 3'b111, 4'b0000},
    {1'b1, 3'd2, 3'd2, 1'b1, 3'b101, 4'b0100},
    {1'b1, 3'd6, 3'd6, 1'b1, 3'b001, 4'b1100}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] v);
    wr_en = 1'b1;
    wr_speed = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 shdn_n", {7'd0, shdn_n}, 8'h00);
    chk("R1 fs_n", {5'd0, fs_n}, 8'h07);
    chk("R1 od_pull", {4'd0, od_pull}, 8'h00);
    rst_n = 1'b1;
    idle(2);

    for (int v = 0; v < 8; v++) begin
      fan_mode = VEC[v][14];
      wr(VEC[v][13:11]);
      idle(K + 2);
      chk($sformatf("R2 vec%0d rd_data", v), rd_data, {5'd0, VEC[v][10:8]});
      chk($sformatf("R3 vec%0d shdn_n", v), {7'd0, shdn_n}, {7'd0, VEC[v][7]});
      chk($sformatf("R3 vec%0d fs_n", v), {5'd0, fs_n}, {5'd0, VEC[v][6:4]});
      chk($sformatf("R8 vec%0d od_pull", v), {4'd0, od_pull}, {4'd0, VEC[v][3:0]});
    end

    // R5: steady 6 -> 3, no boost
    wr(3'd3);
    chk("R5 immediate fs_n", {5'd0, fs_n}, 8'h04);
    chk("R5 immediate shdn_n", {7'd0, shdn_n}, 8'h01);

    // R9: zero while off
    wr(3'd0);
    idle(2);
    wr(3'd0);
    chk("R9 fs_n after zero-on-zero", {5'd0, fs_n}, 8'h07);
    chk("R9 shdn_n after zero-on-zero", {7'd0, shdn_n}, 8'h00);

    // R4: boost length
    fan_mode = 1'b1;
    wr(3'd2);
    chk("R4 first boost cycle fs_n", {5'd0, fs_n}, 8'h00);
    chk("R4 first boost shdn_n", {7'd0, shdn_n}, 8'h01);
    chk("R8 pull during boost", {4'd0, od_pull}, 8'h0E);
    chk("R2 rd during boost", rd_data, 8'h02);
    idle(K - 1);
    chk("R4 last boost cycle fs_n", {5'd0, fs_n}, 8'h00);
    idle(1);
    chk("R4 after boost fs_n", {5'd0, fs_n}, 8'h05);

    // R6: rewrite during boost does not restart
    wr(3'd0);
    wr(3'd1);
    idle(5);
    wr(3'd4);
    chk("R6 still boosted", {5'd0, fs_n}, 8'h00);
    idle(K - 7);
    chk("R6 last original boost cycle", {5'd0, fs_n}, 8'h00);
    idle(1);
    chk("R6 new code at original end", {5'd0, fs_n}, 8'h03);

    // R7: zero during boost cancels
    wr(3'd0);
    wr(3'd5);
    idle(3);
    wr(3'd0);
    chk("R7 cancel shdn_n", {7'd0, shdn_n}, 8'h00);
    chk("R7 cancel fs_n", {5'd0, fs_n}, 8'h07);
    idle(K);
    chk("R7 stays off", {5'd0, fs_n}, 8'h07);
    wr(3'd6);
    idle(K - 1);
    chk("R7 fresh full boost", {5'd0, fs_n}, 8'h00);
    idle(1);
    chk("R7 after fresh boost", {5'd0, fs_n}, 8'h01);

    // R8: leaving fan mode drops pulls
    fan_mode = 1'b0;
    idle(1);
    chk("R8 no pull out of mode", {4'd0, od_pull}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule